// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block produces horizontal sync, vertical sync and a data-enable strobe for a raster display. It does not track line and frame position with binary counters. It uses two 16-bit linear feedback shift registers instead: one steps per pixel and the other steps per line. Each timing event fires when a running shift register equals a programmed state, so each counter needs only a shift and a small XOR, and each event needs only an equality compare.

Every programmed event value is the shift-register state reached a given number of steps after the seed. Software therefore pre-steps each wanted count before writing it. The two active-size limits are the exception and are written as plain binary counts. The block also reports, as binary numbers, the column and row of the current pixel inside the active window, which a pixel-fetch stage can use as addresses.

The block has no data path, so it has no valid/ready handshake and no back-pressure. A pixel-clock enable paces all progress. A two-bit blanking control can suppress the data enable, or the data enable and both syncs. Timing registers are captured into shadow copies during reset and at each frame boundary, so a frame always runs on one consistent set of values.

Top module: `lfsr_video_timing`

## Requirements
- R1: Each position counter is a 16-bit shift register seeded with 0xFFFF. One step shifts it left by one bit and fills bit 0 with bit15 XOR bit4 XOR bit2 XOR bit1. Every value written to a `*_cmp` port is the state reached after N such steps from the seed, which stands for the count N.
- R2: `h_total_cmp` encoding N gives lines of N+1 enabled pixel clocks. When the horizontal counter matches it, the counter returns to the seed on the next enabled clock.
- R3: `v_total_cmp` encoding M gives frames of M+1 lines, numbered 0 to M. The vertical counter steps once at the end of each line and returns to the seed after line M.
- R4: `hsync` is active high. With `h_sync_end_cmp` encoding K, it is high at pixel positions 1 to K-1 of every line and low elsewhere.
- R5: `vsync` is active high. With `v_sync_end_cmp` encoding K, it is high for all of lines 0 to K-1 and low elsewhere.
- R6: With blanking mode 0, `de` is high exactly when the pixel position lies in [S,E) of the horizontal active compares and the line lies in [S,E) of the vertical active compares.
- R7: An active window also closes once it has lasted `h_act_len` pixels (or `v_act_len` lines), if that comes before its end compare.
- R8: `px_x` is the pixel index inside the horizontal window, starting at 0, and is 0 outside it. `px_y` is the line index inside the vertical window, starting at 0, and is 0 outside it.
- R9: `blank_mode` acts at once. Value 0 is display on. Value 1 holds `de` low while both syncs keep running. Values 2 and 3 power the output down: `hsync`, `vsync` and `de` are all low. Counting continues in every mode.
- R10: While `pix_ce` is low, no output and no position changes.
- R11: New timing inputs take effect only from the first pixel of the next frame. The current frame completes with the values it started with.
- R12: During reset the block captures the timing inputs. After reset it sits at pixel 0 of line 0 with `hsync` low, `vsync` high (line 0 is in the sync band), `de` low and both coordinates 0.
- R13: The coordinates cover active widths up to 2048, so `px_x` reaches 2047 in a 2048-pixel window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; timing inputs are captured while it is low |
| pix_ce | input | 1 | Pixel clock enable; one pixel step per enabled clock |
| blank_mode | input | 2 | 0 on, 1 blank, 2 or 3 power-down |
| h_total_cmp | input | 16 | Encoded last pixel index of a line |
| h_sync_end_cmp | input | 16 | Encoded position where hsync ends |
| h_act_start_cmp | input | 16 | Encoded first active pixel |
| h_act_end_cmp | input | 16 | Encoded first pixel after the active span |
| h_act_len | input | 12 | Binary cap on active pixels per line |
| v_total_cmp | input | 16 | Encoded last line index of a frame |
| v_sync_end_cmp | input | 16 | Encoded line where vsync ends |
| v_act_start_cmp | input | 16 | Encoded first active line |
| v_act_end_cmp | input | 16 | Encoded first line after the active span |
| v_act_len | input | 12 | Binary cap on active lines per frame |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| px_x | output | 12 | Column inside the active window |
| px_y | output | 12 | Row inside the active window |

## Verification
The assertions depend on four conditions holding for the inputs:
- Each encoded compare is a state the counter reaches before its own end compare.
- No active window runs across the wrap of its counter.
- Both binary length caps are nonzero.
- A change of timing values never shrinks a window that is currently open.

The stimulus meets these conditions. It builds every encoded value by stepping the shift register from the seed through counts that are smaller than the line or frame total. Every window ends before its wrap, and each new configuration is driven between clock edges while the bench's own model defers its use to the next frame boundary.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int LW = 16;
  localparam int CW = 12;
  localparam logic [LW-1:0] SEED = '1;
  localparam logic [LW-1:0] TAPS = 16'h8016;

  typedef logic [LW-1:0] lstate_t;
  typedef logic [CW-1:0] coord_t;

  typedef struct packed {
    lstate_t end_st;
    lstate_t sync_end_st;
    lstate_t act_start_st;
    lstate_t act_end_st;
    coord_t  act_len;
  } axis_cfg_t;

  typedef enum logic [1:0] {
    BLK_ON    = 2'd0,
    BLK_BLANK = 2'd1,
    BLK_OFF   = 2'd2,
    BLK_OFF2  = 2'd3
  } blank_e;

  function automatic lstate_t lfsr_next(lstate_t v);
    return {v[LW-2:0], ^(v & TAPS)};
  endfunction

  function automatic lstate_t lfsr_walk(int n);
    lstate_t v = SEED;
    for (int i = 0; i < n; i++) v = lfsr_next(v);
    return v;
  endfunction
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int SYNC_START_STEPS = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  axis_cfg_t cfg,
  output logic      wrap,
  output logic      sync,
  output logic      act,
  output coord_t    coord
);
  localparam lstate_t SYNC_START = lfsr_walk(SYNC_START_STEPS);

  lstate_t pos_q, pos_nxt;
  logic    sync_q, act_q;
  coord_t  coord_q;
  logic    at_end, enter_act, leave_act, cap_hit;

  always_comb begin
    at_end    = (pos_q == cfg.end_st);
    pos_nxt   = at_end ? SEED : lfsr_next(pos_q);
    enter_act = (pos_nxt == cfg.act_start_st);
    cap_hit   = (coord_q == coord_t'(cfg.act_len - coord_t'(1)));
    leave_act = act_q && ((pos_nxt == cfg.act_end_st) || cap_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= SEED;
      sync_q  <= (SYNC_START == SEED);
      act_q   <= (cfg.act_start_st == SEED);
      coord_q <= '0;
    end else if (adv) begin
      pos_q <= pos_nxt;
      if (pos_nxt == cfg.sync_end_st)  sync_q <= 1'b0;
      else if (pos_nxt == SYNC_START)  sync_q <= 1'b1;
      if (enter_act) begin
        act_q   <= 1'b1;
        coord_q <= '0;
      end else if (leave_act) begin
        act_q   <= 1'b0;
        coord_q <= '0;
      end else if (act_q) begin
        coord_q <= coord_q + coord_t'(1);
      end
    end
  end

  assign wrap  = adv && at_end;
  assign sync  = sync_q;
  assign act   = act_q;
  assign coord = coord_q;

  // R1: a shift register started from a nonzero seed never locks at zero
  a_r1_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q != '0);

  // R2 (pixel axis) and R3 (line axis): a match restarts at the seed
  a_r2_wrap_seed: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (pos_q == SEED));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(pos_q) && $stable(coord_q) && $stable(sync_q) && $stable(act_q)));

  a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (coord_q < cfg.act_len));

  a_r8_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (coord_q == '0));
endmodule

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
#(
  parameter int NAX = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  axis_cfg_t cfg_in [NAX],
  output axis_cfg_t cfg_q  [NAX]
);
  for (genvar a = 0; a < NAX; a++) begin : g_ax
    always_ff @(posedge clk) begin
      if (!rst_n || load) cfg_q[a] <= cfg_in[a];
    end

    a_r11_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_q[a]));
  end
endmodule

// File: rtl/vtg_out.sv
module vtg_out
  import vtg_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       h_sync,
  input  logic       v_sync,
  input  logic       h_act,
  input  logic       v_act,
  output logic       hsync,
  output logic       vsync,
  output logic       de
);
  blank_e m;
  logic   run;

  always_comb begin
    m     = blank_e'(mode);
    run   = (m == BLK_ON) || (m == BLK_BLANK);
    hsync = run && h_sync;
    vsync = run && v_sync;
    de    = (m == BLK_ON) && h_act && v_act;
  end
endmodule

// File: rtl/lfsr_video_timing.sv
module lfsr_video_timing
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  logic [1:0]    blank_mode,
  input  logic [LW-1:0] h_total_cmp,
  input  logic [LW-1:0] h_sync_end_cmp,
  input  logic [LW-1:0] h_act_start_cmp,
  input  logic [LW-1:0] h_act_end_cmp,
  input  logic [CW-1:0] h_act_len,
  input  logic [LW-1:0] v_total_cmp,
  input  logic [LW-1:0] v_sync_end_cmp,
  input  logic [LW-1:0] v_act_start_cmp,
  input  logic [LW-1:0] v_act_end_cmp,
  input  logic [CW-1:0] v_act_len,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] px_x,
  output logic [CW-1:0] px_y
);
  localparam int NAX = 2;

  axis_cfg_t cfg_in [NAX];
  axis_cfg_t cfg_sh [NAX];
  logic      h_wrap, v_wrap, h_sync, v_sync, h_act, v_act;
  coord_t    h_coord, v_coord;

  always_comb begin
    cfg_in[0] = '{end_st: h_total_cmp, sync_end_st: h_sync_end_cmp,
                  act_start_st: h_act_start_cmp, act_end_st: h_act_end_cmp,
                  act_len: h_act_len};
    cfg_in[1] = '{end_st: v_total_cmp, sync_end_st: v_sync_end_cmp,
                  act_start_st: v_act_start_cmp, act_end_st: v_act_end_cmp,
                  act_len: v_act_len};
  end

  vtg_shadow #(.NAX(NAX)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(v_wrap), .cfg_in(cfg_in), .cfg_q(cfg_sh)
  );

  vtg_axis #(.SYNC_START_STEPS(1)) u_hax (
    .clk(clk), .rst_n(rst_n), .adv(pix_ce), .cfg(cfg_sh[0]),
    .wrap(h_wrap), .sync(h_sync), .act(h_act), .coord(h_coord)
  );

  vtg_axis #(.SYNC_START_STEPS(0)) u_vax (
    .clk(clk), .rst_n(rst_n), .adv(h_wrap), .cfg(cfg_sh[1]),
    .wrap(v_wrap), .sync(v_sync), .act(v_act), .coord(v_coord)
  );

  vtg_out u_out (
    .mode(blank_mode), .h_sync(h_sync), .v_sync(v_sync), .h_act(h_act),
    .v_act(v_act), .hsync(hsync), .vsync(vsync), .de(de)
  );

  assign px_x = h_coord;
  assign px_y = v_coord;
endmodule

// File: tb/sim_lfsr_video_timing.sv
module sim_lfsr_video_timing;
  logic clk = 1'b0, rst_n = 1'b0, pix_ce = 1'b0;
  logic [1:0]  blank_mode = 2'd0;
  logic [15:0] h_total_cmp, h_sync_end_cmp, h_act_start_cmp, h_act_end_cmp;
  logic [15:0] v_total_cmp, v_sync_end_cmp, v_act_start_cmp, v_act_end_cmp;
  logic [11:0] h_act_len, v_act_len;
  logic        hsync, vsync, de;
  logic [11:0] px_x, px_y;

  int checks = 0, errors = 0;
  int p_ht, p_hsw, p_hds, p_hdw, p_hlen, p_vt, p_vsw, p_vds, p_vdw, p_vlen;
  int m_ht, m_hsw, m_hds, m_hdw, m_hlen, m_vt, m_vsw, m_vds, m_vdw, m_vlen;
  int hp, vp, maxx;
  string sc;

  always #4 clk = ~clk;

  lfsr_video_timing u0 (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .blank_mode(blank_mode),
    .h_total_cmp(h_total_cmp), .h_sync_end_cmp(h_sync_end_cmp),
    .h_act_start_cmp(h_act_start_cmp), .h_act_end_cmp(h_act_end_cmp),
    .h_act_len(h_act_len), .v_total_cmp(v_total_cmp),
    .v_sync_end_cmp(v_sync_end_cmp), .v_act_start_cmp(v_act_start_cmp),
    .v_act_end_cmp(v_act_end_cmp), .v_act_len(v_act_len),
    .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y)
  );

  // R1: state after n steps from the seed
  function automatic logic [15:0] lf(int n);
    logic [15:0] v = 16'hFFFF;
    for (int i = 0; i < n; i++) v = {v[14:0], v[15] ^ v[4] ^ v[2] ^ v[1]};
    return v;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic set_cfg(int ht, int hsw, int hds, int hdw, int hlen,
                         int vt, int vsw, int vds, int vdw, int vlen);
    p_ht = ht; p_hsw = hsw; p_hds = hds; p_hdw = hdw; p_hlen = hlen;
    p_vt = vt; p_vsw = vsw; p_vds = vds; p_vdw = vdw; p_vlen = vlen;
    h_total_cmp = lf(ht - 1);    h_sync_end_cmp = lf(hsw + 1);
    h_act_start_cmp = lf(hds);   h_act_end_cmp = lf(hds + hdw);
    h_act_len = 12'(hlen);
    v_total_cmp = lf(vt);        v_sync_end_cmp = lf(vsw);
    v_act_start_cmp = lf(vds);   v_act_end_cmp = lf(vds + vdw);
    v_act_len = 12'(vlen);
  endtask

  task automatic model_load();
    m_ht = p_ht; m_hsw = p_hsw; m_hds = p_hds; m_hdw = p_hdw; m_hlen = p_hlen;
    m_vt = p_vt; m_vsw = p_vsw; m_vds = p_vds; m_vdw = p_vdw; m_vlen = p_vlen;
  endtask

  task automatic model_adv();
    if (hp == m_ht - 1) begin
      hp = 0;
      if (vp == m_vt) begin vp = 0; model_load(); end
      else vp++;
    end else hp++;
  endtask

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL [%s] %s: got %0d expected %0d (line %0d pixel %0d) t=%0t",
               sc, rq, act, exp, vp, hp, $time);
    end
  endtask

  task automatic cmp();
    bit on, run, hwin, vwin;
    on   = (blank_mode == 2'd0);
    run  = (blank_mode < 2'd2);
    hwin = (hp >= m_hds) && (hp < m_hds + imin(m_hdw, m_hlen));
    vwin = (vp >= m_vds) && (vp < m_vds + imin(m_vdw, m_vlen));
    chk("R4 hsync", int'(hsync), int'(run && hp >= 1 && hp <= m_hsw));
    chk("R5 vsync", int'(vsync), int'(run && vp < m_vsw));
    chk("R6 de",    int'(de),    int'(on && hwin && vwin));
    chk("R8 px_x",  int'(px_x),  hwin ? hp - m_hds : 0);
    chk("R8 px_y",  int'(px_y),  vwin ? vp - m_vds : 0);
    if (de && int'(px_x) > maxx) maxx = int'(px_x);
  endtask

  task automatic step(bit ce);
    @(negedge clk);
    cmp();
    pix_ce = ce;
    if (ce) model_adv();
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) step((gap == 0) ? 1'b1 : ((i % gap) != 0));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pix_ce = 1'b0; blank_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hp = 0; vp = 0; maxx = 0;
    model_load();
  endtask

  task automatic t_reset();
    sc = "R12 reset state";
    set_cfg(40, 4, 8, 24, 24, 20, 2, 4, 12, 12);
    do_reset();
    @(negedge clk);
    chk("R12 hsync", int'(hsync), 0);
    chk("R12 vsync", int'(vsync), 1);
    chk("R12 de", int'(de), 0);
    chk("R12 px_x", int'(px_x), 0);
    chk("R12 px_y", int'(px_y), 0);
  endtask

  task automatic t_basic();
    sc = "R1/R2/R3 two full frames";
    run(2 * 40 * 21 + 5, 0);
  endtask

  task automatic t_cap();
    sc = "R7/R11 binary caps applied at frame start";
    run(300, 0);
    set_cfg(40, 4, 8, 24, 16, 20, 2, 4, 12, 8);
    run(3 * 40 * 21, 0);
  endtask

  task automatic t_ce_gaps();
    sc = "R10 pixel-enable gaps";
    run(2000, 3);
    for (int i = 0; i < 8; i++) step(1'b0);
    run(200, 2);
  endtask

  task automatic t_blank();
    sc = "R9 blanking modes";
    blank_mode = 2'd1; run(500, 0);
    blank_mode = 2'd2; run(500, 0);
    blank_mode = 2'd3; run(500, 0);
    blank_mode = 2'd0; run(500, 0);
  endtask

  task automatic t_update();
    sc = "R11 mid-frame timing change";
    set_cfg(40, 4, 8, 24, 24, 20, 2, 4, 12, 12);
    do_reset();
    run(300, 0);
    set_cfg(48, 6, 10, 30, 30, 18, 3, 3, 10, 10);
    run(840 + 3 * 48 * 19, 0);
  endtask

  task automatic t_wide();
    sc = "R13 2048-pixel window";
    set_cfg(2100, 10, 40, 2048, 2048, 4, 1, 1, 2, 2);
    do_reset();
    run(2100 * 5 + 10, 0);
    chk("R13 largest px_x with de", maxx, 2047);
  endtask

  initial begin
    set_cfg(40, 4, 8, 24, 24, 20, 2, 4, 12, 12);
    t_reset();
    t_basic();
    t_cap();
    t_ce_gaps();
    t_blank();
    t_update();
    t_wide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete in time");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule